// File: doc/BRIEF.md
# IR Remote Transmit Waveform Generator

This block builds the transmit waveform for an infrared remote control. One of four source tick strobes is selected and divided by a power of two. Each divided tick advances two counters. The first is an 8-bit carrier counter that shapes the carrier duty cycle. The second is a 16-bit length counter that switches the carrier on and off to form data marks and spaces. The result is one output pin with a selectable polarity.

Software controls the block through a write port with four registers:

- **Control (address 0):** enable, software reset, invert, run and counter reset.
- **Clock setup (address 1):** source code in bits [1:0] and divider code in bits [7:4].
- **Carrier shape (address 2):** high width in bits [7:0] and period in bits [15:8].
- **Data length (address 3):** 16 bits.

Writing the control register also sets the operating mode, which has three states:

- **OFF:** the enable bit is 0.
- **STOP:** enabled, with the run bit 0.
- **RUN:** enabled, with the run bit 1.

Any control write moves the mode to the state that its enable and run bits name. This covers OFF→STOP, OFF→RUN, STOP↔RUN, STOP→OFF and RUN→OFF.

A counter reset uses a second small machine. **IDLE** moves to **ARM** when the command is accepted. ARM moves to **FIRE** on the next divided tick. FIRE clears the counters on the tick after that and returns to IDLE. A software reset forces IDLE from any state. The status port shows the command as busy in every state except IDLE.

Top module: `irtx_top`

## Requirements
- R1: After reset, the mode is OFF, the invert bit is 0, the source and divider codes are 0, busy is 0 and the output is 0.
- R2: The source code (0 internal, 1 low-speed, 2 high-speed, 3 external) selects which bit of `src_tick` feeds the divider. Pulses on the other three bits have no effect on the output.
- R3: For sources 0 and 2, divider code n (0 to 15) produces one divided tick every 2^n selected pulses.
- R4: For sources 1 and 3, codes 0 to 8 divide by 2^n and code 15 divides by 1. A clock-setup write that pairs one of these sources with a code from 9 to 14 is ignored, so both fields keep their previous values.
- R5: A clock-setup write is ignored while the mode is not OFF.
- R6: While running, the carrier counter advances on each divided tick and wraps to 0 after reaching the period value, so it repeats every period+1 ticks. The carrier is high while the counter is below the high width.
- R7: A data gate starts on. Each time the length counter reaches the length value, the counter wraps to 0 and the gate toggles, so the gate toggles every length+1 ticks. The raw output is carrier AND gate.
- R8: Control bit 3 starts counting when it is 1 and stops counting when it is 0. Bit 0 enables the block. `stat_run` reads 1 only in RUN and `stat_en` reads 1 outside OFF. Counters hold their values outside RUN.
- R9: Control bit 2 inverts the output. Outside RUN, the output equals the invert bit.
- R10: A control write with bit 4 set starts a counter reset only when the mode was already enabled before that write. Busy then reads 1. The counters are zeroed and the gate is turned on at the second divided tick, and busy then returns to 0.
- R11: A control write with bit 1 set drops busy to 0 and abandons any pending counter reset. It also takes priority over bit 4 in the same write.
- R12: When the clearing tick of a counter reset coincides with a running count, the clear wins and the counters restart from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | One-cycle enable strobes from the four clock sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| ir_out | output | 1 | Modulated transmit output |
| stat_en | output | 1 | Module enabled |
| stat_run | output | 1 | Counting in progress |
| stat_busy | output | 1 | Counter reset in progress |
| stat_inv | output | 1 | Current invert bit |
| cfg_src | output | 2 | Accepted source code |
| cfg_div | output | 4 | Accepted divider code |

## Verification
A counter reset and normal counting can act on the same divided tick. The bench forces this by issuing the reset while the block is running with a divide ratio of 1. The first source pulse then advances the counters, and the second pulse is the clearing tick. The waveform over the following pulses must match a tick count that restarts at zero, not one that kept climbing. The bench also puts the software-reset and counter-reset bits in one write and judges by the busy flag, which must stay low.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_STOP = 2'd1,
        MODE_RUN  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        CLR_IDLE = 2'd0,
        CLR_ARM  = 2'd1,
        CLR_FIRE = 2'd2
    } clr_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CLK  = 2'd1;
    localparam logic [1:0] ADDR_CAR  = 2'd2;
    localparam logic [1:0] ADDR_LEN  = 2'd3;

    localparam int B_EN   = 0;
    localparam int B_SWR  = 1;
    localparam int B_INV  = 2;
    localparam int B_RUN  = 3;
    localparam int B_CRST = 4;

    // sources 1 and 3 are the slow ones
    function automatic logic src_is_slow(input logic [1:0] s);
        return s[0];
    endfunction

endpackage

// File: rtl/irtx_prescaler.sv
module irtx_prescaler
    import irtx_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [3:0]       src_tick,
    input  logic [1:0]       src,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [DIV_W-1:0] exp_sel;
    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] cnt_q;
    logic             tick_q;
    logic             sel;

    always_comb begin
        exp_sel = (src_is_slow(src) && (div == '1)) ? '0 : div;
        limit   = PRE_W'((32'd1 << exp_sel) - 32'd1);
        sel     = src_tick[src];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (!active) begin
                cnt_q <= '0;
            end else if (sel) begin
                if (cnt_q == limit) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign tick = tick_q;
endmodule

// File: rtl/irtx_ctrl.sv
module irtx_ctrl
    import irtx_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CAR_W    = 8,
    parameter int LEN_W    = 16,
    parameter int DIV_W    = 4,
    parameter int SLOW_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output mode_e             mode,
    output logic              inv,
    output logic [1:0]        src,
    output logic [DIV_W-1:0]  div,
    output logic [CAR_W-1:0]  hi,
    output logic [CAR_W-1:0]  per,
    output logic [LEN_W-1:0]  len,
    output logic              crst_req,
    output logic              swr
);
    localparam logic [DIV_W-1:0] SLOW_CODE = DIV_W'(SLOW_MAX);

    mode_e            mode_q, mode_d;
    logic             ctrl_wr, clk_wr, car_wr, len_wr, clk_ok;
    logic [1:0]       new_src;
    logic [DIV_W-1:0] new_div;

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
        clk_wr  = wr_en && (wr_addr == ADDR_CLK);
        car_wr  = wr_en && (wr_addr == ADDR_CAR);
        len_wr  = wr_en && (wr_addr == ADDR_LEN);
        new_src = wr_data[1:0];
        new_div = wr_data[DIV_W+3:4];
        clk_ok  = clk_wr && (mode_q == MODE_OFF) &&
                  (!src_is_slow(new_src) || (new_div <= SLOW_CODE) || (new_div == '1));
    end

    // mode transitions on control writes
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_OFF: begin
                if (ctrl_wr && wr_data[B_EN])
                    mode_d = wr_data[B_RUN] ? MODE_RUN : MODE_STOP;
            end
            MODE_STOP: begin
                if (ctrl_wr)
                    mode_d = !wr_data[B_EN] ? MODE_OFF :
                             (wr_data[B_RUN] ? MODE_RUN : MODE_STOP);
            end
            MODE_RUN: begin
                if (ctrl_wr)
                    mode_d = !wr_data[B_EN] ? MODE_OFF :
                             (wr_data[B_RUN] ? MODE_RUN : MODE_STOP);
            end
            default: mode_d = MODE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_OFF;
            inv      <= 1'b0;
            src      <= '0;
            div      <= '0;
            hi       <= '0;
            per      <= '0;
            len      <= '0;
            crst_req <= 1'b0;
            swr      <= 1'b0;
        end else begin
            mode_q   <= mode_d;
            crst_req <= ctrl_wr && wr_data[B_CRST] && !wr_data[B_SWR] &&
                        (mode_q != MODE_OFF);
            swr      <= ctrl_wr && wr_data[B_SWR];
            if (ctrl_wr) inv <= wr_data[B_INV];
            if (clk_ok) begin
                src <= new_src;
                div <= new_div;
            end
            if (car_wr) begin
                hi  <= wr_data[CAR_W-1:0];
                per <= wr_data[2*CAR_W-1:CAR_W];
            end
            if (len_wr) len <= wr_data[LEN_W-1:0];
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/irtx_wavegen.sv
module irtx_wavegen
    import irtx_pkg::*;
#(
    parameter int CAR_W = 8,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             running,
    input  logic             crst_req,
    input  logic             swr,
    input  logic [CAR_W-1:0] hi,
    input  logic [CAR_W-1:0] per,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             raw
);
    clr_e             clr_q, clr_d;
    logic             wipe;
    logic [CAR_W-1:0] ccnt_q;
    logic [LEN_W-1:0] dcnt_q;
    logic             gate_q;

    always_comb begin
        clr_d = clr_q;
        if (swr) begin
            clr_d = CLR_IDLE;
        end else begin
            unique case (clr_q)
                CLR_IDLE: if (crst_req) clr_d = CLR_ARM;
                CLR_ARM:  if (tick)     clr_d = CLR_FIRE;
                CLR_FIRE: if (tick)     clr_d = CLR_IDLE;
                default:                clr_d = CLR_IDLE;
            endcase
        end
        wipe = (clr_q == CLR_FIRE) && tick && !swr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_q <= CLR_IDLE;
        else        clr_q <= clr_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccnt_q <= '0;
            dcnt_q <= '0;
            gate_q <= 1'b1;
        end else if (wipe) begin
            ccnt_q <= '0;
            dcnt_q <= '0;
            gate_q <= 1'b1;
        end else if (tick && running) begin
            ccnt_q <= (ccnt_q == per) ? '0 : ccnt_q + 1'b1;
            if (dcnt_q == len) begin
                dcnt_q <= '0;
                gate_q <= !gate_q;
            end else begin
                dcnt_q <= dcnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy = (clr_q != CLR_IDLE);
        raw  = running && gate_q && (ccnt_q < hi);
    end
endmodule

// File: rtl/irtx_top.sv
module irtx_top
    import irtx_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CAR_W    = 8,
    parameter int LEN_W    = 16,
    parameter int DIV_W    = 4,
    parameter int SLOW_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        src_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ir_out,
    output logic              stat_en,
    output logic              stat_run,
    output logic              stat_busy,
    output logic              stat_inv,
    output logic [1:0]        cfg_src,
    output logic [DIV_W-1:0]  cfg_div
);
    mode_e            mode;
    logic             inv, crst_req, swr, div_tick, raw, busy;
    logic [1:0]       src;
    logic [DIV_W-1:0] div;
    logic [CAR_W-1:0] hi, per;
    logic [LEN_W-1:0] len;

    irtx_ctrl #(
        .DATA_W(DATA_W), .CAR_W(CAR_W), .LEN_W(LEN_W),
        .DIV_W(DIV_W), .SLOW_MAX(SLOW_MAX)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .inv(inv), .src(src), .div(div),
        .hi(hi), .per(per), .len(len), .crst_req(crst_req), .swr(swr)
    );

    irtx_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .active(mode != MODE_OFF),
        .src_tick(src_tick), .src(src), .div(div), .tick(div_tick)
    );

    irtx_wavegen #(.CAR_W(CAR_W), .LEN_W(LEN_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .tick(div_tick),
        .running(mode == MODE_RUN), .crst_req(crst_req), .swr(swr),
        .hi(hi), .per(per), .len(len), .busy(busy), .raw(raw)
    );

    always_comb begin
        ir_out    = raw ^ inv;
        stat_en   = (mode != MODE_OFF);
        stat_run  = (mode == MODE_RUN);
        stat_busy = busy;
        stat_inv  = inv;
        cfg_src   = src;
        cfg_div   = div;
    end
endmodule

// File: rtl/irtx_chk.sv
module irtx_chk #(
    parameter int DIV_W    = 4,
    parameter int SLOW_MAX = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ir_out,
    input logic             stat_en,
    input logic             stat_run,
    input logic             stat_busy,
    input logic             stat_inv,
    input logic [1:0]       cfg_src,
    input logic [DIV_W-1:0] cfg_div,
    input logic             crst_req,
    input logic             swr
);
    localparam logic [DIV_W-1:0] SLOW_CODE = DIV_W'(SLOW_MAX);

    assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_en |=> ($stable(cfg_src) && $stable(cfg_div)));

    assert_idle_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_run |-> (ir_out == stat_inv));

    assert_slow_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_src[0] |-> ((cfg_div <= SLOW_CODE) || (cfg_div == '1)));

    assert_swr_drops_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> !stat_busy);

    assert_busy_from_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_busy) |-> $past(crst_req));
endmodule

bind irtx_top irtx_chk #(.DIV_W(DIV_W), .SLOW_MAX(SLOW_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .ir_out(ir_out), .stat_en(stat_en),
    .stat_run(stat_run), .stat_busy(stat_busy), .stat_inv(stat_inv),
    .cfg_src(cfg_src), .cfg_div(cfg_div), .crst_req(crst_req), .swr(swr)
);

// File: tb/test_irtx_top.sv
module test_irtx_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ir_out, stat_en, stat_run, stat_busy, stat_inv;
    logic [1:0]  cfg_src;
    logic [3:0]  cfg_div;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    irtx_top i_irtx_top (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ir_out(ir_out),
        .stat_en(stat_en), .stat_run(stat_run), .stat_busy(stat_busy),
        .stat_inv(stat_inv), .cfg_src(cfg_src), .cfg_div(cfg_div)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        src_tick[s] = 1'b1;
        @(negedge clk);
        src_tick = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // expected output after k divided ticks counted from zero
    function automatic int exp_out(int k, int hi, int per, int len, int inv);
        int c;
        int g;
        c = k % (per + 1);
        g = ((k / (len + 1)) % 2) == 0;
        return inv ^ ((g != 0) && (c < hi));
    endfunction

    // control word: en bit0, swr bit1, inv bit2, run bit3, crst bit4
    function automatic logic [15:0] cw(int en, int swr, int inv, int run, int crst);
        return 16'((en & 1) | ((swr & 1) << 1) | ((inv & 1) << 2) |
                   ((run & 1) << 3) | ((crst & 1) << 4));
    endfunction

    task automatic run_cfg(input int s, input int d, input int ratio, input int nt,
                           input int hi, input int per, input int len, input int inv);
        int k;
        wr(2'd0, cw(0, 0, 0, 0, 0));
        wr(2'd1, 16'((d << 4) | s));
        chk("R2/R4 source accepted", cfg_src, s);
        chk("R3/R4 divider accepted", cfg_div, d);
        wr(2'd2, 16'((per << 8) | hi));
        wr(2'd3, 16'(len));
        wr(2'd0, cw(1, 0, inv, 0, 0));
        chk("R9 stopped output", ir_out, inv);
        wr(2'd0, cw(1, 0, inv, 0, 1));
        chk("R10 busy set", stat_busy, 1);
        for (int p = 0; p < 2 * ratio; p++) pulse(s);
        chk("R10 busy cleared after two ticks", stat_busy, 0);
        wr(2'd0, cw(1, 0, inv, 1, 0));
        chk("R8 run status", stat_run, 1);
        chk("R6/R7 start", ir_out, exp_out(0, hi, per, len, inv));
        for (int p = 1; p <= nt * ratio; p++) begin
            pulse(s);
            k = p / ratio;
            if (p == 3 * ratio) begin
                pulse((s + 1) % 4);
                chk("R2 foreign source ignored", ir_out, exp_out(k, hi, per, len, inv));
            end
            if (ratio <= 4 || (p % ratio) == 0 || (p % ratio) == ratio - 1)
                chk("R3/R6/R7 waveform", ir_out, exp_out(k, hi, per, len, inv));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out", ir_out, 0);
        chk("R1 en", stat_en, 0);
        chk("R1 run", stat_run, 0);
        chk("R1 busy", stat_busy, 0);
        chk("R1 inv", stat_inv, 0);
        chk("R1 src", cfg_src, 0);
        chk("R1 div", cfg_div, 0);

        // divider and waveform sweep
        run_cfg(0, 0, 1, 24, 2, 4, 6, 0);
        run_cfg(0, 1, 2, 16, 1, 3, 4, 1);
        run_cfg(0, 2, 4, 12, 3, 5, 5, 0);
        run_cfg(0, 3, 8, 10, 2, 3, 3, 1);
        run_cfg(2, 4, 16, 6, 1, 2, 2, 0);
        run_cfg(1, 15, 1, 20, 3, 4, 7, 0);
        run_cfg(1, 2, 4, 10, 2, 2, 3, 1);
        run_cfg(3, 8, 256, 3, 1, 1, 1, 0);

        // R9 disable while running, invert while stopped
        wr(2'd0, cw(0, 0, 0, 0, 0));
        chk("R9 disabled output", ir_out, 0);
        chk("R8 en status off", stat_en, 0);
        chk("R8 run status off", stat_run, 0);
        wr(2'd0, cw(1, 0, 1, 0, 0));
        chk("R9 inverted idle", ir_out, 1);
        chk("R9 inv status", stat_inv, 1);

        // R5 lock while enabled
        wr(2'd0, cw(0, 0, 0, 0, 0));
        wr(2'd1, 16'((2 << 4) | 0));
        wr(2'd0, cw(1, 0, 0, 0, 0));
        wr(2'd1, 16'((5 << 4) | 2));
        chk("R5 src locked", cfg_src, 0);
        chk("R5 div locked", cfg_div, 2);

        // R4 slow source rejection
        wr(2'd0, cw(0, 0, 0, 0, 0));
        wr(2'd1, 16'((10 << 4) | 1));
        chk("R4 reject src", cfg_src, 0);
        chk("R4 reject div", cfg_div, 2);
        wr(2'd1, 16'((9 << 4) | 3));
        chk("R4 reject code 9", cfg_div, 2);
        wr(2'd1, 16'((14 << 4) | 0));
        chk("R3 fast code 14 accepted", cfg_div, 14);
        wr(2'd1, 16'((0 << 4) | 0));

        // R10 crst ignored when enabling in same write
        wr(2'd0, cw(1, 0, 0, 0, 1));
        chk("R10 crst from off ignored", stat_busy, 0);

        // R11 swr aborts, and wins in same write
        wr(2'd0, cw(1, 0, 0, 0, 1));
        chk("R10 busy before swr", stat_busy, 1);
        wr(2'd0, cw(1, 1, 0, 0, 0));
        chk("R11 swr clears busy", stat_busy, 0);
        for (int p = 0; p < 3; p++) pulse(0);
        chk("R11 stays idle", stat_busy, 0);
        wr(2'd0, cw(1, 1, 0, 0, 1));
        chk("R11 swr beats crst", stat_busy, 0);

        // R12 clear coincides with counting
        run_cfg(0, 0, 1, 5, 2, 4, 6, 0);
        wr(2'd0, cw(1, 0, 0, 1, 1));
        chk("R12 busy", stat_busy, 1);
        pulse(0);
        chk("R12 counting tick", ir_out, exp_out(6, 2, 4, 6, 0));
        chk("R12 still busy", stat_busy, 1);
        pulse(0);
        chk("R12 clear wins", ir_out, exp_out(0, 2, 4, 6, 0));
        chk("R12 busy done", stat_busy, 0);
        for (int k = 1; k <= 16; k++) begin
            pulse(0);
            chk("R12 restart from zero", ir_out, exp_out(k, 2, 4, 6, 0));
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule